// File: doc/BRIEF.md
# Two-Phase Interleaved Leading-Edge PWM

This block produces the high-side and low-side switch commands for two synchronous buck phases. Each phase has its own sawtooth counter that runs over a programmable number of clock cycles, and the second phase's counter starts half a period after the first. The two phases therefore share one period length and switch 180 degrees apart.

Modulation is leading-edge. A phase's high-side switch turns on in the cycle after that phase's comparator bit reports that the error signal has met the ramp. The comparator bit is already digitised and comes from an external analog loop. The high-side switch turns off at the phase's period boundary. Every period begins with a low-side window that cannot be shortened. Its length is the larger of two values: a fixed minimum low-side time, and the off-time implied by a maximum duty percentage of the programmed period.

A light-load input parks phase A with both of its switches off, while phase B keeps switching. A fault input forces both phases into the safe state (high-side off, low-side on) in the same cycle.

Top module: `dual_phase_le_pwm`

## Requirements
- R1: While `en` is low and `fault` is low, all four switch outputs are 0. This includes the state held during and right after reset.
- R2: A phase never drives its high-side and low-side outputs to 1 at the same time. While the phase is enabled, not parked and not faulted, `ls` is the inverse of `hs`.
- R3: Counts in a period are numbered 0 to P-1, where count 0 is the first cycle after a boundary. If the comparator of a running phase is 1 at count k, with gate <= k < P-1, then `hs` goes to 1 from count k+1 through count P-1. That gives a high run of P-1-k cycles.
- R4: `hs` goes to 0 at the period boundary. In a period in which the comparator is never 1, `hs` stays at 0 for the whole period.
- R5: The gate is max(MIN_LO, P - floor(P*MAX_DUTY_PCT/100)). `hs` cannot be 1 at or before count `gate`, so every low-side run before a turn-on lasts at least gate+1 cycles. With the default parameters (MIN_LO=6, MAX_DUTY_PCT=90): for P=40 the gate is 6, and for P=100 the gate is 10.
- R6: A comparator pulse at a count below the gate is held. The turn-on then happens at count gate+1.
- R7: A comparator pulse at count P-1 is dropped at the boundary and does not turn the phase on in the next period.
- R8: Phase B's count equals (phase A's count + floor(P/2)) mod P. With equal comparator inputs, a rising edge of `hs_b` follows a rising edge of `hs_a` by P/2 cycles when P is even.
- R9: While `light` is 1 and `fault` is 0, `hs_a` and `ls_a` are both 0, and phase B keeps switching once per period.
- R10: While `fault` is 1, `hs_a` and `hs_b` are 0 and `ls_a` and `ls_b` are 1 in the same cycle, whatever the values of `en` and `light`.
- R11: After `fault` falls, after `en` rises, or after `light` falls, the affected phase cannot turn on again until after its next period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; while low, the counters are reloaded and all switches are off |
| period | input | PW | Phase period P in clock cycles (P >= 4, held stable while `en` is high) |
| cmp_a | input | 1 | Phase A comparator trip |
| cmp_b | input | 1 | Phase B comparator trip |
| light | input | 1 | Light-load mode: park phase A |
| fault | input | 1 | Force high-side off and low-side on in both phases |
| hs_a | output | 1 | Phase A high-side command |
| ls_a | output | 1 | Phase A low-side command |
| hs_b | output | 1 | Phase B high-side command |
| ls_b | output | 1 | Phase B low-side command |

## Verification
The minimum-low-run property assumes three things: `period` stays constant while `en` is high, `period` is never below 4, and the gate is below P-1. The stimulus changes `period` only while `en` is low and uses only P=40 and P=100. The fault and park properties are combinational. For that reason the bench changes `fault` and `light` only at falling clock edges, and it reads the outputs one time unit later. Comparator pulses are placed by counting falling edges from an observed high-side fall. An observed high-side fall marks count 0 of phase A.

// File: rtl/dual_phase_le_pwm.sv
module dual_phase_le_pwm #(
  parameter int PW           = 10,
  parameter int MIN_LO       = 6,
  parameter int MAX_DUTY_PCT = 90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  input  logic          cmp_a,
  input  logic          cmp_b,
  input  logic          light,
  input  logic          fault,
  output logic          hs_a,
  output logic          ls_a,
  output logic          hs_b,
  output logic          ls_b
);
  localparam int MW = PW + 8;

  logic [MW-1:0] prod, max_on, lo_need, gate;
  logic [PW-1:0] half;
  logic [1:0]    cmp, park, hs, ls;

  assign prod    = MW'(period) * MW'(MAX_DUTY_PCT);
  assign max_on  = prod / MW'(100);
  assign lo_need = MW'(period) - max_on;
  assign gate    = (lo_need > MW'(MIN_LO)) ? lo_need : MW'(MIN_LO);
  assign half    = period >> 1;
  assign cmp     = {cmp_b, cmp_a};
  assign park    = {1'b0, light};

  for (genvar i = 0; i < 2; i++) begin : g_ph
    logic [PW-1:0] cnt;
    logic          hsq, trip, hold, wrap, block;

    assign wrap  = cnt >= period - PW'(1);
    assign block = fault | park[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        hsq  <= 1'b0;
        trip <= 1'b0;
        hold <= 1'b1;
      end else if (!en) begin
        cnt  <= (i == 0) ? '0 : half;
        hsq  <= 1'b0;
        trip <= 1'b0;
        hold <= 1'b1;
      end else begin
        cnt  <= wrap ? '0 : cnt + PW'(1);
        trip <= wrap ? 1'b0 : (trip | cmp[i]);
        if (block) begin
          hsq  <= 1'b0;
          hold <= 1'b1;
        end else if (wrap) begin
          hsq  <= 1'b0;
          hold <= 1'b0;
        end else if (!hold && MW'(cnt) >= gate && (cmp[i] | trip)) begin
          hsq <= 1'b1;
        end
      end
    end

    assign hs[i] = en & ~park[i] & ~fault & hsq;
    assign ls[i] = fault | (en & ~park[i] & ~hsq);
  end

  assign hs_a = hs[0];
  assign ls_a = ls[0];
  assign hs_b = hs[1];
  assign ls_b = ls[1];
endmodule

// File: rtl/dual_phase_le_pwm_chk.sv
module dual_phase_le_pwm_chk #(
  parameter int MIN_LO = 6
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic light,
  input logic fault,
  input logic hs_a,
  input logic ls_a,
  input logic hs_b,
  input logic ls_b
);
  logic [15:0] lo_a, lo_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_a <= '0;
      lo_b <= '0;
    end else begin
      lo_a <= hs_a ? '0 : ((lo_a == 16'hFFFF) ? lo_a : lo_a + 16'd1);
      lo_b <= hs_b ? '0 : ((lo_b == 16'hFFFF) ? lo_b : lo_b + 16'd1);
    end
  end

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !fault) |-> (!hs_a && !ls_a && !hs_b && !ls_b));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a && ls_a) && !(hs_b && ls_b));

  // R5
  min_low_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_a) |-> (lo_a >= 16'(MIN_LO + 1)));

  // R5
  min_low_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_b) |-> (lo_b >= 16'(MIN_LO + 1)));

  // R9
  park_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (light && !fault) |-> (!hs_a && !ls_a));

  // R10
  fault_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (ls_a && ls_b && !hs_a && !hs_b));
endmodule

bind dual_phase_le_pwm dual_phase_le_pwm_chk #(.MIN_LO(MIN_LO)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .light(light), .fault(fault),
  .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
);

// File: tb/dual_phase_le_pwm_test.sv
`timescale 1ns/1ps
module dual_phase_le_pwm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [9:0] period = 10'd40;
  logic       cmp_a = 1'b1, cmp_b = 1'b1, light = 1'b0, fault = 1'b0;
  logic       hs_a, ls_a, hs_b, ls_b;
  int checks = 0, errors = 0;
  bit done = 0;

  dual_phase_le_pwm uut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .light(light), .fault(fault), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input int p);
    @(negedge clk);
    en = 1'b0; period = 10'(p); cmp_a = 1'b1; cmp_b = 1'b1; light = 1'b0; fault = 1'b0;
    @(negedge clk);
    en = 1'b1;
  endtask

  // leaves the bench at the sample where phase A count is 0
  task automatic wait_fall_a();
    for (int n = 0; n < 500 && !hs_a; n++) @(negedge clk);
    for (int n = 0; n < 500 && hs_a; n++) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    check(!hs_a && !ls_a && !hs_b && !ls_b, "R1 reset outputs", {hs_a, ls_a, hs_b, ls_b}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!hs_a && !ls_a && !hs_b && !ls_b, "R1 disabled outputs", {hs_a, ls_a, hs_b, ls_b}, 0);
  endtask

  task automatic t_steady(input int p, input int exp_lo, input int exp_hi, input string tag);
    int lo = 1, hi = 1, bad = 0;
    start(p);
    wait_fall_a();
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      if (ls_a == hs_a) bad++;
      if (hs_a) break;
      lo++;
    end
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      if (ls_a == hs_a) bad++;
      if (!hs_a) break;
      hi++;
    end
    check(lo == exp_lo, {tag, " low run"}, lo, exp_lo);
    check(hi == exp_hi, "R3 high run to boundary", hi, exp_hi);
    check(bad == 0, "R2 complementary", bad, 0);
  endtask

  task automatic t_offset();
    int n = 0;
    logic prev;
    start(40);
    for (int k = 0; k < 500 && !hs_a; k++) @(negedge clk);
    for (int k = 0; k < 500 && hs_a; k++) @(negedge clk);
    for (int k = 0; k < 500 && !hs_a; k++) @(negedge clk);
    prev = hs_b;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      n++;
      if (!prev && hs_b) break;
      prev = hs_b;
    end
    check(n == 20, "R8 phase B offset", n, 20);
  endtask

  // k < 0: no trip during the period
  task automatic t_trip(input int k, input int exp_lo, input int exp_hi, input string tag);
    int lo = 1, hi = 1;
    start(40);
    wait_fall_a();
    cmp_a = 1'b0;
    for (int s = 1; s < 100; s++) begin
      @(negedge clk);
      cmp_a = (s == k);
      if (hs_a) break;
      lo++;
    end
    cmp_a = 1'b0;
    if (k < 0 || k >= 39) begin
      check(lo >= 99, tag, lo, 99);
    end else begin
      for (int n = 0; n < 200; n++) begin
        @(negedge clk);
        if (!hs_a) break;
        hi++;
      end
      check(lo == exp_lo, tag, lo, exp_lo);
      check(hi == exp_hi, "R3 high run after trip", hi, exp_hi);
    end
    cmp_a = 1'b1;
  endtask

  task automatic t_light();
    int bad = 0, rises = 0;
    logic prev;
    start(40);
    wait_fall_a();
    light = 1'b1;
    #1;
    check(!hs_a && !ls_a, "R9 park same cycle", {hs_a, ls_a}, 0);
    prev = hs_b;
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      if (hs_a || ls_a) bad++;
      if (!prev && hs_b) rises++;
      prev = hs_b;
    end
    check(bad == 0, "R9 phase A parked", bad, 0);
    check(rises == 2, "R9 phase B still switching", rises, 2);
    light = 1'b0;
  endtask

  task automatic t_fault();
    int lo = 1;
    start(40);
    for (int k = 0; k < 500 && !hs_a; k++) @(negedge clk);
    for (int k = 0; k < 500 && hs_a; k++) @(negedge clk);
    for (int k = 0; k < 500 && !hs_a; k++) @(negedge clk);
    for (int k = 0; k < 10; k++) @(negedge clk);
    fault = 1'b1;
    #1;
    check(!hs_a && ls_a && !hs_b && ls_b, "R10 fault same cycle", {hs_a, ls_a, hs_b, ls_b}, 5);
    @(negedge clk);
    fault = 1'b0;
    #1;
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      if (hs_a) break;
      lo++;
    end
    check(lo == 29, "R11 wait for boundary after fault", lo, 29);
    @(negedge clk);
    en = 1'b0; light = 1'b1; fault = 1'b1;
    #1;
    check(!hs_a && ls_a && !hs_b && ls_b, "R10 fault overrides en and light", {hs_a, ls_a, hs_b, ls_b}, 5);
    @(negedge clk);
    fault = 1'b0; light = 1'b0;
  endtask

  initial begin
    t_reset();
    t_steady(40, 7, 33, "R5 min-low gate");
    t_steady(100, 11, 89, "R5 duty-cap gate");
    t_offset();
    t_trip(20, 21, 19, "R3 late trip");
    t_trip(2, 7, 33, "R6 early trip held");
    t_trip(6, 7, 33, "R5 trip at gate");
    t_trip(39, 0, 0, "R7 last-count trip dropped");
    t_trip(-1, 0, 0, "R4 no trip stays low");
    t_light();
    t_fault();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule